// File: doc/BRIEF.md
# Password Attempt Tamper Guard

This block sits in front of the password-protected command path of a device. For every password attempt it receives a one-cycle strobe and a flag saying whether the supplied password matched. The password itself is stored and compared elsewhere. Each wrong password advances a 4-bit failure counter. Normal operation cannot clear this counter; only a reset-device command or the master reset clears it.

Every accepted attempt opens a busy window of a fixed number of clock cycles, and the window is the same for right and wrong passwords. An observer timing the response or watching supply current therefore learns nothing about the result. The eighth wrong password raises a sticky tamper flag. The sixteenth wrong password wraps the counter to zero and locks the block. While locked, password-class commands are refused and further attempts are dropped. Plain commands and the reset-device command stay permitted. The locked state is also presented at bit 32 of a device-ID status word.

Top module: `pw_guard`

## Requirements
- R1: After master reset (`mrst_n` low), `busy`, `tamper` and `locked` are 0, `id_flags` is all zeros, and the failure count is zero, so exactly sixteen wrong passwords are needed to lock.
- R2: An accepted attempt raises `busy` on the next clock edge and holds it for exactly `BUSY_CYC` cycles. A matching attempt and a mismatching attempt give the same window.
- R3: An attempt strobed while `busy` is high is ignored. It is not counted and it does not extend or restart the window.
- R4: An accepted attempt with `try_match`=1 leaves the failure count unchanged. An accepted attempt with `try_match`=0 adds one to the count.
- R5: `tamper` rises on the edge that accepts the eighth counted failure. It stays set through the reset-device command and is cleared only by master reset.
- R6: The sixteenth counted failure wraps the 4-bit count from 15 to 0, and `locked` rises on that same edge.
- R7: `cmd_kind` encodes 0 = plain, 1 = password, 2 = reset-device, 3 = plain. `permit` is 0 only when `locked`=1 and `cmd_kind`=1. Otherwise it is 1.
- R8: While `locked` is 1, attempts are dropped: `busy` does not rise and nothing is counted.
- R9: A `dev_reset` pulse clears the failure count and `locked` on the next edge. It takes priority over an attempt strobed in the same cycle, and that attempt is dropped without opening a busy window.
- R10: `id_flags` bit 32 equals `locked`, and every other bit of `id_flags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| try_vld | input | 1 | One-cycle strobe marking a password attempt |
| try_match | input | 1 | Comparison result for the attempt: 1 = correct |
| dev_reset | input | 1 | Reset-device command pulse |
| cmd_kind | input | 2 | Class of the command being decoded (see R7) |
| busy | output | 1 | Fixed-length window after an accepted attempt |
| tamper | output | 1 | Sticky flag: eight failures have been counted |
| locked | output | 1 | Counter has overflowed; password commands are refused |
| permit | output | 1 | Current `cmd_kind` may proceed |
| id_flags | output | 40 | Device-ID status word; bit 32 carries `locked` |

## Verification
The bench builds the block with `BUSY_CYC` = 5 instead of the long default. A full lockout then takes sixteen attempts of six cycles each, and the bench can walk through every count value, the tamper threshold and the wrap. The counter width stays at its default of 4, so the overflow point checked is the real one. Strobes placed in the middle of a window, and a reset-device command landing together with an attempt, test the acceptance rules.

// File: rtl/pw_guard_pkg.sv
package pw_guard_pkg;
  typedef enum logic [1:0] {
    CMD_PLAIN  = 2'd0,
    CMD_PASSWD = 2'd1,
    CMD_DEVRST = 2'd2,
    CMD_PLAIN2 = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/pw_busy_timer.sv
module pw_busy_timer #(
  parameter int BUSY_CYC = 500000
) (
  input  logic clk,
  input  logic mrst_n,
  input  logic start,
  output logic busy_o
);
  localparam int TMR_W = $clog2(BUSY_CYC + 1);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= TMR_W'(BUSY_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TMR_W'(1);
    end
  end

  assign busy_o = (cnt_q != '0);

  // R2: the window only closes after its last counted cycle
  p_window_end_r2: assert property (@(posedge clk) disable iff (!mrst_n)
    $fell(busy_o) |-> $past(cnt_q) == TMR_W'(1));

  // R2: a start always yields a busy cycle next
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!mrst_n)
    start |=> busy_o);
endmodule

// File: rtl/pw_fail_ctr.sv
module pw_fail_ctr #(
  parameter int CNT_W     = 4,
  parameter int TAMPER_AT = 8
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tamper_o,
  output logic             locked_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] TAMP_PRE = CNT_W'(TAMPER_AT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tamper_q;
  logic             locked_q;

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (clr) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (inc) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_TOP) locked_q <= 1'b1;
    end
  end

  // tamper survives the device reset command; only master reset clears it
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      tamper_q <= 1'b0;
    end else if (inc && !clr && cnt_q == TAMP_PRE) begin
      tamper_q <= 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign tamper_o = tamper_q;
  assign locked_o = locked_q;

  // R5: tamper flag is sticky
  p_tamper_sticky_r5: assert property (@(posedge clk) disable iff (!mrst_n)
    tamper_q |=> tamper_q);

  // R6: lock is entered exactly when the count wraps to zero
  p_lock_on_wrap_r6: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(locked_q) |-> cnt_q == '0 && $past(cnt_q) == CNT_TOP);

  // R9: clear empties the counter and the lock
  p_clear_r9: assert property (@(posedge clk) disable iff (!mrst_n)
    clr |=> cnt_q == '0 && !locked_q);
endmodule

// File: rtl/pw_guard.sv
module pw_guard
  import pw_guard_pkg::*;
#(
  parameter int BUSY_CYC  = 500000,
  parameter int CNT_W     = 4,
  parameter int TAMPER_AT = 8,
  parameter int ID_W      = 40,
  parameter int LOCK_POS  = 32
) (
  input  logic            clk,
  input  logic            mrst_n,
  input  logic            try_vld,
  input  logic            try_match,
  input  logic            dev_reset,
  input  logic [1:0]      cmd_kind,
  output logic            busy,
  output logic            tamper,
  output logic            locked,
  output logic            permit,
  output logic [ID_W-1:0] id_flags
);
  logic             accept;
  logic             fail_inc;
  logic [CNT_W-1:0] fail_cnt;

  // reset-device wins over a simultaneous attempt; busy or locked drop it
  assign accept   = try_vld && !busy && !locked && !dev_reset;
  assign fail_inc = accept && !try_match;

  pw_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk    (clk),
    .mrst_n (mrst_n),
    .start  (accept),
    .busy_o (busy)
  );

  pw_fail_ctr #(.CNT_W(CNT_W), .TAMPER_AT(TAMPER_AT)) u_ctr (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .inc      (fail_inc),
    .clr      (dev_reset),
    .cnt_o    (fail_cnt),
    .tamper_o (tamper),
    .locked_o (locked)
  );

  assign permit = !(locked && cmd_kind == CMD_PASSWD);

  always_comb begin
    id_flags           = '0;
    id_flags[LOCK_POS] = locked;
  end

  // R3: strobes during the window change nothing in the counter
  p_ignore_busy_r3: assert property (@(posedge clk) disable iff (!mrst_n)
    busy && try_vld && !dev_reset |=> $stable(fail_cnt));

  // R4: a matching attempt never moves the counter
  p_match_no_count_r4: assert property (@(posedge clk) disable iff (!mrst_n)
    try_vld && try_match && !dev_reset |=> $stable(fail_cnt));

  // R7: password commands are never let through while locked
  p_refuse_locked_r7: assert property (@(posedge clk) disable iff (!mrst_n)
    locked && cmd_kind == 2'd1 |-> !permit);

  // R8: once locked and idle, no window opens
  p_locked_quiet_r8: assert property (@(posedge clk) disable iff (!mrst_n)
    locked && !busy |=> !busy);
endmodule

// File: tb/test_pw_guard.sv
module test_pw_guard;
  localparam int B = 5;

  logic        clk = 1'b0;
  logic        mrst_n = 1'b0;
  logic        try_vld = 1'b0;
  logic        try_match = 1'b0;
  logic        dev_reset = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic        busy, tamper, locked, permit;
  logic [39:0] id_flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pw_guard #(.BUSY_CYC(B)) i_pw_guard (
    .clk(clk), .mrst_n(mrst_n), .try_vld(try_vld), .try_match(try_match),
    .dev_reset(dev_reset), .cmd_kind(cmd_kind), .busy(busy),
    .tamper(tamper), .locked(locked), .permit(permit), .id_flags(id_flags)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mreset();
    @(negedge clk);
    mrst_n = 1'b0;
    try_vld = 1'b0;
    dev_reset = 1'b0;
    repeat (2) @(negedge clk);
    mrst_n = 1'b1;
    @(negedge clk);
  endtask

  // one accepted attempt, then wait for the window to close
  task automatic attempt(input logic m);
    try_vld = 1'b1;
    try_match = m;
    @(negedge clk);
    try_vld = 1'b0;
    repeat (B) @(negedge clk);
  endtask

  task automatic fails(input int n);
    for (int i = 0; i < n; i++) attempt(1'b0);
  endtask

  task automatic t_reset();
    mreset();
    chk("R1 busy", busy, 0);
    chk("R1 tamper", tamper, 0);
    chk("R1 locked", locked, 0);
    chk("R1 id_flags", id_flags, 0);
    cmd_kind = 2'd1;
    #1 chk("R1 permit", permit, 1);
  endtask

  task automatic t_busy_len();
    mreset();
    for (int k = 0; k < 2; k++) begin
      try_vld = 1'b1;
      try_match = (k == 0);
      @(negedge clk);
      try_vld = 1'b0;
      chk("R2 busy first", busy, 1);
      repeat (B - 1) @(negedge clk);
      chk("R2 busy last", busy, 1);
      @(negedge clk);
      chk("R2 busy closed", busy, 0);
    end
  endtask

  task automatic t_ignore_busy();
    mreset();
    try_vld = 1'b1;
    try_match = 1'b0;
    @(negedge clk);
    try_vld = 1'b0;
    @(negedge clk);
    try_vld = 1'b1;
    @(negedge clk);
    try_vld = 1'b0;
    @(negedge clk);
    try_vld = 1'b1;
    @(negedge clk);
    try_vld = 1'b0;
    // accept edge + 4 edges passed; window must close after one more
    chk("R3 no restart busy", busy, 1);
    @(negedge clk);
    chk("R3 no restart closed", busy, 0);
    fails(6);
    chk("R3 strobes uncounted", tamper, 0);
    fails(1);
    chk("R3 count resumed", tamper, 1);
  endtask

  task automatic t_match_count();
    mreset();
    fails(7);
    for (int i = 0; i < 5; i++) attempt(1'b1);
    chk("R4 matches uncounted", tamper, 0);
    fails(1);
    chk("R4 R5 eighth failure", tamper, 1);
    dev_reset = 1'b1;
    @(negedge clk);
    dev_reset = 1'b0;
    chk("R5 tamper kept by dev_reset", tamper, 1);
    mreset();
    chk("R5 tamper cleared by master", tamper, 0);
  endtask

  task automatic t_lock();
    mreset();
    fails(15);
    chk("R6 not yet locked", locked, 0);
    try_vld = 1'b1;
    try_match = 1'b0;
    @(negedge clk);
    try_vld = 1'b0;
    chk("R6 locked on wrap", locked, 1);
    chk("R10 id bit32", id_flags, 64'h1 << 32);
    repeat (B) @(negedge clk);
    cmd_kind = 2'd1; #1 chk("R7 password refused", permit, 0);
    cmd_kind = 2'd0; #1 chk("R7 plain allowed", permit, 1);
    cmd_kind = 2'd2; #1 chk("R7 devreset allowed", permit, 1);
    cmd_kind = 2'd3; #1 chk("R7 code3 allowed", permit, 1);
    @(negedge clk);
    try_vld = 1'b1;
    try_match = 1'b1;
    @(negedge clk);
    try_vld = 1'b0;
    chk("R8 no busy when locked", busy, 0);
    // R9: reset-device together with an attempt
    dev_reset = 1'b1;
    try_vld = 1'b1;
    try_match = 1'b0;
    @(negedge clk);
    dev_reset = 1'b0;
    try_vld = 1'b0;
    chk("R9 unlocked", locked, 0);
    chk("R9 attempt dropped", busy, 0);
    chk("R10 id cleared", id_flags, 0);
    fails(15);
    chk("R9 count cleared", locked, 0);
    fails(1);
    chk("R9 relock after 16", locked, 1);
  endtask

  initial begin
    t_reset();
    t_busy_len();
    t_ignore_busy();
    t_match_count();
    t_lock();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule